// File: doc/BRIEF.md
# Local Interrupt Controller Timer

This block is the countdown timer of a per-core local interrupt controller. Software sets up a timer vector entry, a divide code and an initial count over a small register bus. The divide code selects how many core clock cycles make one timer tick. Writing the initial count starts a new run that is timed from that write. When the run reaches its end, the block pulses an interrupt request for one cycle and presents the programmed 8-bit vector.

The timer has two modes. In one-shot mode it expires once, after initial count plus one ticks. In periodic mode it expires every initial count plus one ticks, each time measured from the load. A periodic run with a zero count never expires. A mask bit in the vector entry stops any interrupt from being raised, but the count keeps running while masked. A current-count register lets software watch the countdown.

Top module: `lapic_timer`

## Requirements
- R1: After reset, the vector entry reads 0x0001_0000 (masked, one-shot, vector 0), and the divide code, initial count and current count all read 0. `irq_o` is low, and until the first divide write the tick rate is one tick per core cycle.
- R2: Address 0 is the vector entry, with vector in bits [7:0], mask in bit 16 and periodic mode in bit 17; all other bits read 0. Address 1 holds the divide code in bits [2:0]. Address 2 is the initial count. Address 3 is the current count, is read-only, and writes to it are ignored.
- R3: A divide code c from 0 to 6 gives one tick every 2^(c+1) core cycles. Code 7 gives one tick per core cycle.
- R4: For a run loaded by a write at edge E, the elapsed tick count k cycles after E is k >> s, where s is the divide shift. The current count is never above the initial count.
- R5: In one-shot mode, `irq_o` is high in exactly one cycle, (N+1) << s cycles after E, where N is the initial count. After that the current count reads 0; before it, it reads N minus the elapsed ticks.
- R6: In periodic mode with N > 0, `irq_o` is high at every whole multiple of (N+1) << s cycles after E. The current count reads N - (elapsed ticks mod (N+1)).
- R7: In periodic mode with N = 0, the timer never raises `irq_o`.
- R8: While the mask bit is set, `irq_o` stays low. The countdown continues as if unmasked.
- R9: Each expiry drives `irq_o` high for exactly one cycle. In that cycle, `irq_vec_o` equals bits [7:0] of the vector entry as they stood at the expiry.
- R10: Writing the initial count restarts the count from the new write edge and cancels any expiry scheduled by an earlier load. In the cycle after the write, the current count equals the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, also the timebase |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | One-cycle interrupt request on expiry |
| irq_vec_o | output | 8 | Vector that goes with `irq_o` |

## Verification
The assertions assume that software changes the divide code and the mode bit only between runs: the divide code before the initial-count write, and the mode bit never while a periodic run with a zero count could switch to one-shot. The random stimulus always writes the divide code and the vector entry before it writes the initial count. Each run is then observed cycle by cycle until the next load, and the expected interrupt cycles and current-count values come from the write edge and the programmed shift. Directed cases cover the slowest divide, a reload in the middle of a run, a write to the read-only register, and reset defaults.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned DIV_CODE_W = 3;
  localparam int unsigned SHIFT_W    = 3;
  localparam int unsigned MASK_POS   = 16;
  localparam int unsigned MODE_POS   = 17;

  typedef enum logic [1:0] {
    REG_LVT  = 2'd0,
    REG_DIV  = 2'd1,
    REG_INIT = 2'd2,
    REG_CUR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } lvt_t;

  // code 7 is the divide-by-1 escape; the rest divide by 2^(code+1)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_CODE_W-1:0] code);
    return (code == '1) ? '0 : SHIFT_W'(code) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/lapic_timer_regs.sv
module lapic_timer_regs
  import lapic_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [CNT_W-1:0]      cur_cnt_i,
  output lvt_t                  lvt_o,
  output logic [SHIFT_W-1:0]    shift_o,
  output logic [CNT_W-1:0]      init_o,
  output logic                  load_o,
  output logic [DATA_W-1:0]     rdata_o
);
  lvt_t                  lvt_q;
  logic [DIV_CODE_W-1:0] div_q;
  logic [SHIFT_W-1:0]    shift_q;
  logic [CNT_W-1:0]      init_q;
  reg_sel_e              sel;

  assign sel    = reg_sel_e'(addr_i);
  assign load_o = we_i && (sel == REG_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvt_q   <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
      div_q   <= '0;
      shift_q <= '0;
      init_q  <= '0;
    end else if (we_i) begin
      unique case (sel)
        REG_LVT: begin
          lvt_q.vector   <= wdata_i[VEC_W-1:0];
          lvt_q.masked   <= wdata_i[MASK_POS];
          lvt_q.periodic <= wdata_i[MODE_POS];
        end
        REG_DIV: begin
          div_q   <= wdata_i[DIV_CODE_W-1:0];
          shift_q <= div_shift(wdata_i[DIV_CODE_W-1:0]);
        end
        REG_INIT: init_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_LVT: begin
        rdata_o[VEC_W-1:0] = lvt_q.vector;
        rdata_o[MASK_POS]  = lvt_q.masked;
        rdata_o[MODE_POS]  = lvt_q.periodic;
      end
      REG_DIV:  rdata_o = DATA_W'(div_q);
      REG_INIT: rdata_o = DATA_W'(init_q);
      REG_CUR:  rdata_o = DATA_W'(cur_cnt_i);
      default:  rdata_o = '0;
    endcase
  end

  assign lvt_o   = lvt_q;
  assign shift_o = shift_q;
  assign init_o  = init_q;
endmodule

// File: rtl/lapic_timer_prescale.sv
module lapic_timer_prescale
  import lapic_timer_pkg::*;
#(
  parameter int unsigned TB_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [TB_W-1:0] now_q;
  logic [TB_W-1:0] load_q;
  logic [TB_W-1:0] since_load;
  logic [TB_W-1:0] low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q  <= '0;
      load_q <= '0;
    end else begin
      now_q <= now_q + TB_W'(1);
      // first cycle after the write sees zero elapsed cycles
      if (load_i) load_q <= now_q + TB_W'(1);
    end
  end

  assign since_load = now_q - load_q;
  assign low_mask   = (TB_W'(1) << shift_i) - TB_W'(1);
  // a tick completes when the cycle count since load crosses a 2^shift boundary
  assign tick_o     = ((since_load + TB_W'(1)) & low_mask) == '0;
endmodule

// File: rtl/lapic_timer_core.sv
module lapic_timer_core
  import lapic_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  lvt_t             lvt_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [CNT_W-1:0] cur_o
);
  logic             armed_q;
  logic [CNT_W-1:0] phase_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  logic             zero_period;
  logic             expire;

  assign zero_period = lvt_i.periodic && (init_i == '0);
  assign expire      = armed_q && tick_i && !load_i && !zero_period && (phase_q == init_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      phase_q <= '0;
    end else if (load_i) begin
      phase_q <= '0;
      armed_q <= !(lvt_i.periodic && (load_val_i == '0));
    end else if (armed_q && tick_i) begin
      if (phase_q == init_i) begin
        phase_q <= '0;
        if (!lvt_i.periodic) armed_q <= 1'b0;
      end else begin
        phase_q <= phase_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !lvt_i.masked;
      if (expire) vec_q <= lvt_i.vector;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
  assign cur_o     = armed_q ? (init_i - phase_q) : '0;
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TB_W   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  lvt_t               lvt;
  logic [SHIFT_W-1:0] shift;
  logic [CNT_W-1:0]   init_q;
  logic [CNT_W-1:0]   cur_cnt;
  logic               load;
  logic               tick;

  lapic_timer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cur_cnt_i (cur_cnt),
    .lvt_o     (lvt),
    .shift_o   (shift),
    .init_o    (init_q),
    .load_o    (load),
    .rdata_o   (reg_rdata_o)
  );

  lapic_timer_prescale #(.TB_W(TB_W)) prescale_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .tick_o  (tick)
  );

  lapic_timer_core #(.CNT_W(CNT_W)) core_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .init_i     (init_q),
    .lvt_i      (lvt),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .cur_o      (cur_cnt)
  );
endmodule

// File: rtl/lapic_timer_chk.sv
module lapic_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              lvt_masked,
  input logic              lvt_periodic,
  input logic              load,
  input logic [CNT_W-1:0]  init_q,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [DATA_W-1:0] reg_wdata_i
);
  assert_mask_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvt_masked |=> !irq_o);

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cur_cnt == $past(reg_wdata_i[CNT_W-1:0])));

  assert_zero_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvt_periodic && (init_q == '0) && !load) |=> !irq_o);

  assert_count_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_cnt <= init_q);
endmodule

bind lapic_timer lapic_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .lvt_masked   (lvt.masked),
  .lvt_periodic (lvt.periodic),
  .load         (load),
  .init_q       (init_q),
  .cur_cnt      (cur_cnt),
  .reg_wdata_i  (reg_wdata_i)
);

// File: tb/lapic_timer_tb_top.sv
module lapic_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic [7:0]  irq_vec_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  lapic_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .irq_vec_o(irq_vec_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int shift_of(input int code);
    return (code == 7) ? 0 : code + 1;
  endfunction

  function automatic logic [31:0] lvt_word(input bit periodic, input bit masked, input logic [7:0] vec);
    return {14'd0, periodic, masked, 8'd0, vec};
  endfunction

  // called at a negedge; the write edge is the next posedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  // called at the negedge of cycle k=0 after an initial-count write
  task automatic watch(input longint n, input int s, input bit periodic, input bit masked,
                       input logic [7:0] vec, input int window, input string tag);
    longint per = (n + 1) << s;
    for (int k = 0; k < window; k++) begin
      longint ticks = longint'(k) >> s;
      bit exp_irq;
      longint exp_cur;
      if (periodic) begin
        exp_irq = (n != 0) && (k > 0) && (longint'(k) % per == 0) && !masked;
        exp_cur = n - (ticks % (n + 1));
      end else begin
        exp_irq = (longint'(k) == per) && !masked;
        exp_cur = (ticks <= n) ? n - ticks : 0;
      end
      reg_addr_i = 2'd3;
      #1;
      check(irq_o == exp_irq, tag, irq_o, exp_irq);
      check(reg_rdata_o == 32'(exp_cur), "R4 current count", reg_rdata_o, exp_cur);
      if (exp_irq) check(irq_vec_o == vec, "R9 vector", irq_vec_o, vec);
      @(negedge clk_i);
    end
  endtask

  task automatic run(input int code, input longint n, input bit periodic, input bit masked,
                     input logic [7:0] vec, input string tag);
    int s = shift_of(code);
    int w;
    wr(2'd1, 32'(code));
    wr(2'd0, lvt_word(periodic, masked, vec));
    wr(2'd2, 32'(n));
    w = periodic ? int'(2 * ((n + 1) << s) + 4) : int'(((n + 1) << s) + 4);
    watch(n, s, periodic, masked, vec, w, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
    rd(2'd0, d); check(d == 32'h0001_0000, "R1 lvt", d, 32'h0001_0000);
    rd(2'd1, d); check(d == 0, "R1 div", d, 0);
    rd(2'd2, d); check(d == 0, "R1 init", d, 0);
    rd(2'd3, d); check(d == 0, "R1 cur", d, 0);
    @(negedge clk_i);
    // R1 divide by 1 until first divide write
    wr(2'd0, lvt_word(1'b0, 1'b0, 8'h21));
    wr(2'd2, 32'd2);
    watch(2, 0, 1'b0, 1'b0, 8'h21, 8, "R1 undivided one-shot");

    // R2 field layout, reserved bits read 0
    wr(2'd0, 32'hFFFF_FF5A);
    rd(2'd0, d); check(d == 32'h0003_005A, "R2 lvt fields", d, 32'h0003_005A);
    @(negedge clk_i);
    wr(2'd1, 32'hFFFF_FFF5);
    rd(2'd1, d); check(d == 32'd5, "R2 div field", d, 5);
    @(negedge clk_i);

    // R2 write to current count ignored
    wr(2'd1, 32'd7);
    wr(2'd0, lvt_word(1'b0, 1'b0, 8'h10));
    wr(2'd2, 32'd50);
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, d); check(d == 32'd49, "R2 cur write ignored", d, 49);
    rd(2'd2, d); check(d == 32'd50, "R2 init after cur write", d, 50);
    @(negedge clk_i);

    // R3 slowest divide and divide-by-1 code
    run(6, 1, 1'b0, 1'b0, 8'hC3, "R3 divide 128 one-shot");
    run(7, 3, 1'b1, 1'b0, 8'h44, "R3 divide 1 periodic");

    // R7 periodic with zero count
    run(0, 0, 1'b1, 1'b0, 8'h77, "R7 zero periodic");

    // R10 reload mid-run cancels old expiry
    wr(2'd1, 32'd7);
    wr(2'd0, lvt_word(1'b0, 1'b0, 8'h99));
    wr(2'd2, 32'd10);
    repeat (5) @(negedge clk_i);
    wr(2'd2, 32'd3);
    watch(3, 0, 1'b0, 1'b0, 8'h99, 20, "R10 reload");

    // R5 R6 R8 random runs
    for (int it = 0; it < 40; it++) begin
      int pick = int'($urandom_range(0, 4));
      int code = (pick == 4) ? 7 : pick;
      longint n = longint'($urandom_range(0, 20));
      bit per = 1'($urandom_range(0, 1));
      bit msk = ($urandom_range(0, 3) == 0);
      logic [7:0] vec = 8'($urandom);
      string tag = msk ? "R8 masked" : (per ? "R6 periodic" : "R5 one-shot");
      run(code, n, per, msk, vec, tag);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule